// File: doc/BRIEF.md
# Soft Reset Handshake Controller

This block sequences the soft reset of a processing engine. Software starts a reset by writing a request bit into a single command/status word. The controller then raises an abort request towards the engine and waits for the engine to acknowledge it. After the acknowledge it moves through two further steps and then holds the engine in soft reset. If the engine never answers, software can write a force bit that skips the wait for the acknowledge.

The sequence can be read back at every step as a 3-bit state code, together with a flag showing that reset is applied and a flag showing that the engine acknowledged before reset was applied. The command bits clear themselves: they act only on the cycle of the write and always read back as zero. A second request write, made once reset is applied, releases the reset and returns the controller to idle.

The acknowledge input may come from another clock domain. It passes through a synchronizer of `SYNC_STAGES` flops before the state machine sees it. The write port is a single-cycle strobe with its data. The read word is combinational from state registers. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `srh_ctrl`

## Requirements
- R1: During and right after reset, the read word is 0x0000_0000 and both `eng_abort_req` and `eng_soft_rst` are low.
- R2: A write with bit 0 (request) set and bit 2 clear, made in IDLE (code 0), moves the state to REQ (code 1) on that clock edge. `eng_abort_req` is high exactly while the state is REQ.
- R3: In REQ, once `eng_abort_ack` has been high for `SYNC_STAGES` edges, the next edge moves to ACK (code 2). The following edges move to ASSERT (code 3) and then SET (code 4), one state per clock, whatever is written.
- R4: In SET, `eng_soft_rst` is high, read bit 3 is 1, and the state stays SET until a request write arrives.
- R5: Read bit 1 is 1 only in SET, and only when SET was reached through the acknowledge path. It is 0 when SET was reached by force.
- R6: A write with bit 2 (force) set, in IDLE or REQ, moves the state straight to ASSERT on that edge, with no acknowledge needed. Force takes priority over request in the same write.
- R7: A request write in SET returns the state to IDLE on that edge. This drops `eng_soft_rst` and clears read bits 3 and 1.
- R8: Request writes in REQ, ACK or ASSERT are ignored. Force writes in ACK, ASSERT or SET are ignored. Writes with neither bit 0 nor bit 2 set have no effect.
- R9: Read bits 0, 2 and 31:7 are always 0. The state code sits in read bits 6:4.
- R10: `eng_abort_ack` has no effect while the state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | DATA_W | Write data: bit 0 request, bit 2 force |
| rd_data | output | DATA_W | Status word: state in 6:4, applied in 3, acknowledged in 1 |
| eng_abort_ack | input | 1 | Abort acknowledge from the engine (may be asynchronous) |
| eng_abort_req | output | 1 | Abort request to the engine |
| eng_soft_rst | output | 1 | Soft reset to the engine, active high |

## Verification
The assertions work only from the ports. They assume that `wr_en` and `wr_data` are known and change away from the clock edge, and that `eng_abort_ack` is a level the engine may raise at any time, including in IDLE. They make no assumption about how long the acknowledge is held, because it is only observed after the synchronizer. The bench drives every input on the falling edge. It raises the acknowledge at a known falling edge, so it can land a write exactly on the single cycle spent in ACK or ASSERT. It resets between sweep points, so the state code before each write is fixed by arithmetic alone.

// File: rtl/srh_pkg.sv
package srh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REQ    = 3'd1,
    ST_ACK    = 3'd2,
    ST_ASSERT = 3'd3,
    ST_SET    = 3'd4
  } srh_state_e;

  localparam int unsigned STATE_W   = 3;
  localparam int unsigned STATE_LSB = 4;
  localparam int unsigned BIT_REQ   = 0;
  localparam int unsigned BIT_ACKD  = 1;
  localparam int unsigned BIT_FRC   = 2;
  localparam int unsigned BIT_STA   = 3;
  localparam int unsigned USED_W    = STATE_LSB + STATE_W;

  typedef struct packed {
    logic req;
    logic frc;
  } srh_cmd_t;

endpackage

// File: rtl/srh_ack_sync.sv
module srh_ack_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_async,
  output logic ack_sync
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign ack_sync = ack_async;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else if (STAGES == 1) chain_q <= ack_async;
        else chain_q <= {chain_q[STAGES-2:0], ack_async};
      end
      assign ack_sync = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/srh_cmd_decode.sv
module srh_cmd_decode
  import srh_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output srh_cmd_t          cmd
);
  localparam logic [DATA_W-1:0] REQ_MASK = DATA_W'(1) << BIT_REQ;
  localparam logic [DATA_W-1:0] FRC_MASK = DATA_W'(1) << BIT_FRC;

  always_comb begin
    cmd.req = wr_en && ((wr_data & REQ_MASK) != '0);
    cmd.frc = wr_en && ((wr_data & FRC_MASK) != '0);
  end
endmodule

// File: rtl/srh_seq_fsm.sv
module srh_seq_fsm
  import srh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  srh_cmd_t   cmd,
  input  logic       ack_s,
  output srh_state_e state,
  output logic       ack_seen
);
  srh_state_e state_q, state_d;
  logic       seen_q, seen_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd.frc)      state_d = ST_ASSERT;
        else if (cmd.req) state_d = ST_REQ;
      end
      ST_REQ: begin
        if (cmd.frc)      state_d = ST_ASSERT;
        else if (ack_s)   state_d = ST_ACK;
      end
      ST_ACK:    state_d = ST_ASSERT;
      ST_ASSERT: state_d = ST_SET;
      ST_SET:    if (cmd.req) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    seen_d = seen_q;
    if (state_q == ST_REQ && state_d == ST_ACK) seen_d = 1'b1;
    else if (state_d == ST_IDLE)                seen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      seen_q  <= seen_d;
    end
  end

  assign state    = state_q;
  assign ack_seen = seen_q;
endmodule

// File: rtl/srh_status_fmt.sv
module srh_status_fmt
  import srh_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  srh_state_e        state,
  input  logic              ack_seen,
  output logic [DATA_W-1:0] rd_data,
  output logic              abort_req,
  output logic              soft_rst
);
  always_comb begin
    abort_req = (state == ST_REQ);
    soft_rst  = (state == ST_SET);
    rd_data   = '0;
    rd_data[STATE_LSB +: STATE_W] = state;
    rd_data[BIT_STA]  = soft_rst;
    rd_data[BIT_ACKD] = soft_rst && ack_seen;
  end
endmodule

// File: rtl/srh_ctrl.sv
module srh_ctrl
  import srh_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eng_abort_ack,
  output logic              eng_abort_req,
  output logic              eng_soft_rst
);
  srh_cmd_t   cmd;
  srh_state_e state;
  logic       ack_s;
  logic       ack_seen;

  srh_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ack_async(eng_abort_ack), .ack_sync(ack_s)
  );

  srh_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .cmd(cmd)
  );

  srh_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ack_s(ack_s),
    .state(state), .ack_seen(ack_seen)
  );

  srh_status_fmt #(.DATA_W(DATA_W)) u_fmt (
    .state(state), .ack_seen(ack_seen), .rd_data(rd_data),
    .abort_req(eng_abort_req), .soft_rst(eng_soft_rst)
  );
endmodule

// File: rtl/srh_ctrl_chk.sv
module srh_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              eng_abort_req,
  input logic              eng_soft_rst
);
  localparam logic [DATA_W-1:0] CMD_MASK = DATA_W'(5);
  localparam logic [DATA_W-1:0] ZERO_MASK = ~DATA_W'(32'h7A);

  logic [2:0] st;
  logic       req_w, frc_w, none_w;
  assign st     = rd_data[6:4];
  assign req_w  = wr_en && wr_data[0];
  assign frc_w  = wr_en && wr_data[2];
  assign none_w = !wr_en || ((wr_data & CMD_MASK) == '0);

  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ZERO_MASK) == '0); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    st <= 3'd4); // R1
  AST_REQ_ONLY_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort_req == (st == 3'd1)); // R2
  AST_IDLE_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 && req_w && !frc_w |=> st == 3'd1); // R2
  AST_ACK_TO_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd2 |=> st == 3'd3); // R3
  AST_ASSERT_TO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd3 |=> st == 3'd4); // R3
  AST_SET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd4 && !req_w |=> st == 3'd4 && eng_soft_rst && rd_data[3]); // R4
  AST_ACKD_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |-> eng_soft_rst); // R5
  AST_FORCE_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 || st == 3'd1) && frc_w |=> st == 3'd3 && !rd_data[1]); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd4 && req_w |=> st == 3'd0 && !eng_soft_rst && rd_data[3:0] == 4'd0); // R7
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd0 && none_w |=> st == 3'd0); // R10
  AST_REQ_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    st == 3'd1 && !frc_w |=> st == 3'd1 || st == 3'd2); // R8
endmodule

bind srh_ctrl srh_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .eng_abort_req(eng_abort_req), .eng_soft_rst(eng_soft_rst)
);

// File: tb/sim_srh_ctrl.sv
`timescale 1ns/1ps
module sim_srh_ctrl;
  localparam int SYNC = 2;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ack = 1'b0;
  logic        abort_req, soft_rst;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  srh_ctrl #(.DATA_W(32), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .eng_abort_ack(ack),
    .eng_abort_req(abort_req), .eng_soft_rst(soft_rst)
  );

  function automatic logic [31:0] exp_rd(int st, bit via_ack);
    logic [31:0] v;
    v = 32'(st) << 4;
    if (st == 4) v = v | 32'h8 | (via_ack ? 32'h2 : 32'h0);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic chk_all(string tag, int st, bit via_ack);
    chk(tag, rd_data, exp_rd(st, via_ack));
    chk({tag, " abort_req"}, {31'd0, abort_req}, {31'd0, st == 1});
    chk({tag, " soft_rst"}, {31'd0, soft_rst}, {31'd0, st == 4});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic int next_st(int s, logic [31:0] p);
    bit rq = p[0], fc = p[2];
    case (s)
      0: return fc ? 3 : (rq ? 1 : 0);
      1: return fc ? 3 : 1;
      2: return 3;
      3: return 4;
      default: return rq ? 0 : 4;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h1; pats[1] = 32'h4; pats[2] = 32'h5;
    pats[3] = 32'h0; pats[4] = 32'hFFFF_FF8A; pats[5] = 32'hFFFF_FFFF;

    // R1: values held in reset and just after release
    #5;
    chk_all("R1 in reset", 0, 0);
    do_reset();
    chk_all("R1 after reset", 0, 0);

    // R10: acknowledge in IDLE ignored
    ack = 1'b1;
    repeat (6) @(negedge clk);
    chk_all("R10 ack in idle", 0, 0);
    // R3: request with ack already high: REQ, then ACK after one edge
    wr(32'h1);
    chk_all("R2 idle to req", 1, 0);
    @(negedge clk); chk_all("R3 req to ack held", 2, 0);
    @(negedge clk); chk_all("R3 ack to assert", 3, 0);
    @(negedge clk); chk_all("R4 set via ack", 4, 1);

    // R6 R5: force path without acknowledge
    do_reset();
    wr(32'h1);
    repeat (5) @(negedge clk);
    chk_all("R2 waits for ack", 1, 0);
    wr(32'h4);
    chk_all("R6 force from req", 3, 0);
    @(negedge clk); chk_all("R5 forced set has no ack flag", 4, 0);
    repeat (3) @(negedge clk); chk_all("R4 set holds", 4, 0);
    wr(32'h1);
    chk_all("R7 clear from set", 0, 0);

    // Sweep: every state code against every write pattern
    for (int s = 0; s < 5; s++) begin
      for (int p = 0; p < 6; p++) begin
        int ns;
        do_reset();
        if (s >= 1) wr(32'h1);
        if (s >= 2) begin
          ack = 1'b1;
          repeat (SYNC + s - 1) @(posedge clk);
          @(negedge clk);
        end
        chk_all($sformatf("R3 step to state %0d", s), s, s == 4);
        wr(pats[p]);
        ns = next_st(s, pats[p]);
        chk_all($sformatf("R8 R9 state %0d pattern %0d", s, p), ns, ns == 4);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule